// File: doc/BRIEF.md
# ADC Four-Channel Readback Sequencer

This controller sits next to a four-channel, simultaneous-sampling converter whose results come out on a parallel bus. The converter has an active-low conversion-complete line, `eoc_n`. A high-to-low transition on that line starts a fixed burst of four active-low read strobes. The four stored channel results therefore appear on the bus one after another. Chip select is held low for the whole burst and released one cycle after the last strobe ends.

Of the four reads, only the one named by a 2-bit binary channel select is kept. For that read the block issues a one-cycle latch strobe at the moment its read strobe returns high, and it stores the 16-bit bus word in an internal capture register with a sticky valid flag. It also presents the 14-bit two's-complement result sign-extended to the full word, and gives a one-cycle data-valid pulse in the cycle after the capture. The block runs from a single 16 MHz clock shared with the converter interface.

Top module: `adc_readback_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cs_n` and `rd_n` are 1 and `latch_stb`, `data_valid` and `cap_valid` are 0.
- R2: A burst starts only when `eoc_n` goes from 1 to 0 while the block is idle. `cs_n` and `rd_n` both go low at the next rising clock edge. Holding `eoc_n` low does not start a further burst.
- R3: Each burst has exactly four `rd_n` low pulses. Each pulse is low for 2 cycles, with 2 high cycles between consecutive pulses.
- R4: `cs_n` stays low from the cycle of the first `rd_n` fall until one cycle after the fourth `rd_n` rise, which is 15 cycles in all. `rd_n` is never low while `cs_n` is high.
- R5: `sel` is sampled when the burst starts. Read number `sel` (0 is the first read) is the selected read. `latch_stb` is high for exactly one cycle, the cycle in which `rd_n` has just returned high after that read, and is never high at any other time.
- R6: At that edge, `cap_data` takes the value `bus_data` held during the selected read, and `cap_valid` becomes 1 and stays 1.
- R7: `cap_sext` equals bits 13:0 of `cap_data` sign-extended from bit 13 to 16 bits.
- R8: `data_valid` is high for exactly one cycle, the cycle right after `latch_stb`.
- R9: A high-to-low transition on `eoc_n` during a burst is ignored. The burst keeps its timing, and no further burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| eoc_n | input | 1 | Converter end-of-conversion, active low |
| sel | input | 2 | Binary number of the read to capture |
| bus_data | input | 16 | Converter parallel data bus |
| cs_n | output | 1 | Converter chip select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| latch_stb | output | 1 | One-cycle capture strobe for the selected read |
| cap_data | output | 16 | Captured bus word |
| cap_sext | output | 16 | Captured 14-bit result, sign-extended |
| cap_valid | output | 1 | Set by the first capture, then held |
| data_valid | output | 1 | One-cycle pulse after each capture |

## Verification
The bench sweeps every select value against several data patterns. A bench-side converter model puts a distinct word on the bus for each read and drives a garbage word between reads. A latch strobe placed one cycle late or early therefore captures the garbage word or a neighbour's result, and a select decoded off by one stores the wrong channel. The bench measures every low and high run of the read strobe and the length of the chip-select window, which catches a wrong pulse count, a wrong phase length, or chip select released too early or too late. Other bursts hold the end-of-conversion line low, then pulse it again, while also changing the select in the middle of the burst. A design that restarts on that edge, or that reads the select live, shows extra pulses or captures the wrong read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } seq_state_t;

endpackage

// File: rtl/eoc_edge_det.sv
module eoc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic eoc_n,
  output logic fall
);

  logic eoc_q;

  always_ff @(posedge clk) begin
    if (rst) eoc_q <= 1'b1;
    else     eoc_q <= eoc_n;
  end

  assign fall = eoc_q & ~eoc_n;

endmodule

// File: rtl/rd_burst_fsm.sv
module rd_burst_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int RD_LOW   = 2,
  parameter int RD_HIGH  = 2,
  localparam int CHAN_W  = $clog2(CHANNELS),
  localparam int PH_MAX  = (RD_LOW > RD_HIGH) ? RD_LOW : RD_HIGH,
  localparam int PH_W    = $clog2(PH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAN_W-1:0] sel,
  output logic              cs_n,
  output logic              rd_n,
  output logic              take
);

  localparam logic [PH_W-1:0]   LOW_LAST  = PH_W'(RD_LOW - 1);
  localparam logic [PH_W-1:0]   HIGH_LAST = PH_W'(RD_HIGH - 1);
  localparam logic [CHAN_W-1:0] CHAN_LAST = CHAN_W'(CHANNELS - 1);

  seq_state_t        state;
  logic [PH_W-1:0]   cnt;
  logic [CHAN_W-1:0] chan;
  logic [CHAN_W-1:0] sel_q;
  logic              cs_n_q;
  logic              rd_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      chan   <= '0;
      sel_q  <= '0;
      cs_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_LOW;
            cs_n_q <= 1'b0;
            rd_n_q <= 1'b0;
            cnt    <= '0;
            chan   <= '0;
            sel_q  <= sel;
          end
        end
        ST_LOW: begin
          if (cnt == LOW_LAST) begin
            rd_n_q <= 1'b1;
            cnt    <= '0;
            state  <= (chan == CHAN_LAST) ? ST_TAIL : ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == HIGH_LAST) begin
            rd_n_q <= 1'b0;
            cnt    <= '0;
            chan   <= chan + 1'b1;
            state  <= ST_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          cs_n_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n = cs_n_q;
  assign rd_n = rd_n_q;
  assign take = (state == ST_LOW) && (cnt == LOW_LAST) && (chan == sel_q);

  // R4
  rd_within_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n_q |-> !cs_n_q);

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> (rd_n_q && $past(rd_n_q)));

  // R2
  cs_with_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> $fell(rd_n_q));

endmodule

// File: rtl/sample_latch.sv
module sample_latch #(
  parameter int DATA_W = 16,
  parameter int RES_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] bus_data,
  output logic              latch_stb,
  output logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] cap_sext,
  output logic              cap_valid,
  output logic              data_valid
);

  localparam int EXT_W = DATA_W - RES_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_stb  <= 1'b0;
      data_valid <= 1'b0;
      cap_valid  <= 1'b0;
      cap_data   <= '0;
    end else begin
      latch_stb  <= take;
      data_valid <= latch_stb;
      if (take) begin
        cap_data  <= bus_data;
        cap_valid <= 1'b1;
      end
    end
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign cap_sext = {{EXT_W{cap_data[RES_W-1]}}, cap_data[RES_W-1:0]};
    end else begin : g_noext
      assign cap_sext = cap_data;
    end
  endgenerate

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb);

  // R8
  dv_follows_stb_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(latch_stb));

endmodule

// File: rtl/adc_readback_seq.sv
module adc_readback_seq #(
  parameter int CHANNELS = 4,
  parameter int DATA_W   = 16,
  parameter int RES_W    = 14,
  parameter int RD_LOW   = 2,
  parameter int RD_HIGH  = 2,
  localparam int SEL_W   = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoc_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] bus_data,
  output logic              cs_n,
  output logic              rd_n,
  output logic              latch_stb,
  output logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] cap_sext,
  output logic              cap_valid,
  output logic              data_valid
);

  logic eoc_fall;
  logic take;

  eoc_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .eoc_n (eoc_n),
    .fall  (eoc_fall)
  );

  rd_burst_fsm #(
    .CHANNELS (CHANNELS),
    .RD_LOW   (RD_LOW),
    .RD_HIGH  (RD_HIGH)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .start (eoc_fall),
    .sel   (sel),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .take  (take)
  );

  sample_latch #(
    .DATA_W (DATA_W),
    .RES_W  (RES_W)
  ) u_latch (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .bus_data   (bus_data),
    .latch_stb  (latch_stb),
    .cap_data   (cap_data),
    .cap_sext   (cap_sext),
    .cap_valid  (cap_valid),
    .data_valid (data_valid)
  );

  // R5
  stb_at_rd_rise_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |-> (rd_n && $past(!rd_n)));

  // R6
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> cap_valid);

endmodule

// File: tb/test_adc_readback_seq.sv
`timescale 1ns/1ps
module test_adc_readback_seq;

  localparam real CLK_PERIOD = 62.5;

  logic        clk = 1'b0;
  logic        rst;
  logic        eoc_n;
  logic [1:0]  sel;
  logic [15:0] bus_data;
  logic        cs_n, rd_n, latch_stb, cap_valid, data_valid;
  logic [15:0] cap_data, cap_sext;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_readback_seq i_adc_readback_seq (
    .clk        (clk),
    .rst        (rst),
    .eoc_n      (eoc_n),
    .sel        (sel),
    .bus_data   (bus_data),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .latch_stb  (latch_stb),
    .cap_data   (cap_data),
    .cap_sext   (cap_sext),
    .cap_valid  (cap_valid),
    .data_valid (data_valid)
  );

  function automatic logic [15:0] word_of(input int b, input int i);
    logic [13:0] v;
    logic [1:0]  t;
    v = 14'(b * 5179 + i * 3001 + 77);
    t = 2'(b + i + 1);
    return {t, v};
  endfunction

  function automatic logic [15:0] sext_of(input logic [15:0] w);
    return {{2{w[13]}}, w[13:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic burst(input int s, input int b, input bit poke);
    int  pulses = 0, cs_low = 0, lo_run = 0, hi_run = 0, bad_w = 0;
    int  stb_n = 0, dv_n = 0;
    bit  stb_ok = 1, dv_ok = 1, prev_rd = 1, prev_stb = 0;
    sel = 2'(s);
    @(negedge clk);
    eoc_n = 1'b0;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (poke && t == 3) sel = 2'(s + 1);
      if (poke && t == 5) eoc_n = 1'b1;
      if (poke && t == 7) eoc_n = 1'b0;
      if (!cs_n) cs_low++;
      if (!rd_n && !cs_n) begin end else if (!rd_n) bad_w++;
      if (!rd_n && prev_rd) begin
        if (pulses > 0 && hi_run != 2) bad_w++;
        pulses++;
        lo_run = 0;
        bus_data = word_of(b, pulses - 1);
      end
      if (rd_n && !prev_rd) begin
        if (lo_run != 2) bad_w++;
        hi_run = 0;
        bus_data = 16'hDEAD;
      end
      if (!rd_n) lo_run++; else hi_run++;
      if (latch_stb) begin
        stb_n++;
        if (!(rd_n && !prev_rd && pulses == s + 1)) stb_ok = 0;
      end
      if (data_valid) begin
        dv_n++;
        if (!prev_stb) dv_ok = 0;
      end
      prev_stb = latch_stb;
      prev_rd  = rd_n;
    end
    eoc_n = 1'b1;
    sel   = 2'(s);
    if (poke) begin
      check("R9 pulses with mid-burst edge", pulses, 4);
      check("R9 cs window with mid-burst edge", cs_low, 15);
    end else begin
      check("R3 pulse count", pulses, 4);
      check("R4 cs low cycles", cs_low, 15);
    end
    check("R2 start only on falling edge", (pulses <= 4), 1);
    check("R3 phase widths", bad_w, 0);
    check("R5 latch strobe placement", {stb_n[15:0], 15'd0, stb_ok}, {16'd1, 16'd1});
    check("R8 data_valid pulse", {dv_n[15:0], 15'd0, dv_ok}, {16'd1, 16'd1});
    check("R6 captured word", cap_data, word_of(b, s));
    check("R6 capture valid", cap_valid, 1);
    check("R7 sign extension", cap_sext, sext_of(word_of(b, s)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    eoc_n = 1'b1;
    sel = 2'd0;
    bus_data = 16'h0000;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 cs_n in reset", cs_n, 1);
    check("R1 rd_n in reset", rd_n, 1);
    check("R1 strobes in reset", {latch_stb, data_valid, cap_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {cs_n, rd_n, latch_stb, data_valid, cap_valid}, 5'b11000);
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 4; s++)
        burst(s, b, 1'b0);
    for (int s = 0; s < 4; s++)
      burst(s, 3, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule